// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a small up-counter that steps through sixteen states in binary, wraps from all ones back to zero, and can be preset to any value from a parallel input. It has two count enables. Both must be high for the counter to step. Only one of them, the trickle enable, also gates the terminal-count flag. This lets several instances be chained into one wider synchronous counter. Each higher stage takes its trickle enable from the terminal-count flag of the stage below. The parallel enable, the load strobe and the clear are shared across all stages.

Each stage has a fixed order of precedence: clear, then load, then count, then hold. The clear input is active low. An elaboration-time parameter decides whether the clear acts at once, independent of the clock, or at the next rising clock edge. Both variants have the same port list. The terminal-count flag is decoded combinationally from the current count and the trickle enable, so the next stage sees it within the same cycle.

Top module: `cascade_ctr4`

## Requirements
- R1: When counting, the count advances from 15 (binary 1111) to 0.
- R2: With ASYNC_CLR=1, a low clr_n forces count to 0 and tc low at once, with no clock edge needed.
- R3: With ASYNC_CLR=0, a low clr_n leaves count unchanged until the next rising clock edge and sets it to 0 at that edge, overriding both load and count.
- R4: With clr_n high and load_n low, the next rising edge copies preset into count, whatever the count enables are.
- R5: With clr_n, load_n, en_par and en_trk all high, each rising edge adds one to count.
- R6: With clr_n and load_n high, and either en_par or en_trk low, count holds its value.
- R7: tc is high exactly when en_trk is high and count is 15, in the same cycle and regardless of en_par.
- R8: After clr_n is released, the first enabled rising edge moves count from 0 to 1, with no added latency.
- R9: Three stages chained tc to en_trk, with en_par, load_n and clr_n shared, track a 12-bit counter through counting, loads and clears. This includes the carries across stage boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous according to ASYNC_CLR |
| load_n | input | 1 | Active-low parallel load strobe |
| en_par | input | 1 | Count enable that does not gate tc |
| en_trk | input | 1 | Count enable that also gates tc |
| preset | input | WIDTH | Value loaded when load_n is low |
| count | output | WIDTH | Current count |
| tc | output | 1 | Terminal-count flag |

## Verification
The bench loads values just below the stage boundaries of a three-stage chain and counts across them. A design that generated carries wrongly, or let en_par gate tc, would skip or repeat a 16 or a 256 boundary. It asserts clear together with load and with counting. In the synchronous variant it also checks the count in the middle of the cycle in which clear is low. A priority error, or a clear that took effect too early, would show up there. In the asynchronous instance, clear is dropped in the middle of a cycle and the count must already be zero before the next edge. The release of clear is followed at once by an enabled edge, so a design that waited an extra cycle would read 0 where 1 is expected.

// File: rtl/ctr_pkg.sv
// Shared types for the cascadable counter.
// Assumes nothing beyond a synthesizable 2-bit enum.
package ctr_pkg;
    // Action selected for the next rising edge, lowest priority first
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } ctr_mode_e;
endpackage

// File: rtl/ctr_mode_dec.sv
// Mode decoder: resolves the control inputs into one action, with the fixed
// precedence clear > load > count > hold. All inputs are active as named
// (clr_n and load_n low-true). Purely combinational.
module ctr_mode_dec
    import ctr_pkg::*;
(
    input  logic      clr_n,
    input  logic      load_n,
    input  logic      en_par,
    input  logic      en_trk,
    output ctr_mode_e mode
);
    // Priority decode of the next action
    always_comb begin
        if (!clr_n)
            mode = MODE_CLEAR;
        else if (!load_n)
            mode = MODE_LOAD;
        else if (en_par && en_trk)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/ctr_next.sv
// Next-state logic: computes the value the count takes at the next edge.
// Assumes WIDTH-bit unsigned arithmetic, so all ones wraps to zero.
module ctr_next
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  ctr_mode_e        mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    // Select the next count from the decoded action
    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = '0;
            MODE_LOAD:  nxt = preset;
            MODE_COUNT: nxt = cur + STEP;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_state_reg.sv
// State register. ASYNC_CLR selects the flavour: 1 gives a register cleared
// at once by a low clr_n, 0 gives a register cleared only at a rising edge.
// In both flavours, d already carries zero when clr_n is low.
module ctr_state_reg #(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (ASYNC_CLR) begin : g_async
            // Register with immediate active-low clear
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) q <= '0;
                else        q <= d;
            end
        end else begin : g_sync
            // Register with edge-timed active-low clear
            always_ff @(posedge clk) begin
                if (!clr_n) q <= '0;
                else        q <= d;
            end
        end
    endgenerate
endmodule

// File: rtl/ctr_tc_dec.sv
// Terminal-count decode: high when the count is all ones and the trickle
// enable is high. Combinational, so a chained stage sees it in the same cycle.
module ctr_tc_dec #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_trk,
    output logic             tc
);
    // All-ones detect gated by the trickle enable
    always_comb tc = en_trk && (&cur);
endmodule

// File: rtl/cascade_ctr4.sv
// Cascadable presettable up-counter stage, modulo 2**WIDTH.
// Assumes the control inputs change away from the rising edge of clk.
// ASYNC_CLR picks an immediate or an edge-timed clear; the port list is the same.
module cascade_ctr4
    import ctr_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_par,
    input  logic             en_trk,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             tc
);
    ctr_mode_e        mode;
    logic [WIDTH-1:0] nxt;

    ctr_mode_dec u_mode (
        .clr_n (clr_n),
        .load_n(load_n),
        .en_par(en_par),
        .en_trk(en_trk),
        .mode  (mode)
    );

    ctr_next #(.WIDTH(WIDTH)) u_next (
        .mode  (mode),
        .cur   (count),
        .preset(preset),
        .nxt   (nxt)
    );

    ctr_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
        .clk  (clk),
        .clr_n(clr_n),
        .d    (nxt),
        .q    (count)
    );

    ctr_tc_dec #(.WIDTH(WIDTH)) u_tc (
        .cur   (count),
        .en_trk(en_trk),
        .tc    (tc)
    );
endmodule

// File: rtl/cascade_ctr4_chk.sv
// Assertion checker for cascade_ctr4, attached by bind. Observes ports only.
module cascade_ctr4_chk #(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             en_par,
    input logic             en_trk,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] count,
    input logic             tc
);
    localparam logic [WIDTH-1:0] TOP = '1;
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk && count == TOP) |=> (count == '0));

    // R4
    load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n) |=> (count == $past(preset)));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk && count != TOP) |=> (count == $past(count) + ONE));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trk)) |=> $stable(count));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!clr_n)
        $past(!clr_n) |-> (count == '0));

    // R7
    tc_chk: assert property (@(posedge clk) disable iff (!clr_n)
        tc == (en_trk && count == TOP));
endmodule

bind cascade_ctr4 cascade_ctr4_chk #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_chk (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .preset(preset), .count(count), .tc(tc)
);

// File: tb/tb_cascade_ctr4.sv
// Bench: a three-stage synchronous-clear chain plus one immediate-clear stage.
module tb_cascade_ctr4;
    logic        clk = 1'b0;
    logic        clr_n = 1'b0, a_clr_n = 1'b0, load_n = 1'b1;
    logic        en_par = 1'b0, en_trk = 1'b0;
    logic [11:0] preset = '0;
    logic [3:0]  q0, q1, q2, aq;
    logic        tc0, tc1, tc2, atc;
    logic [11:0] ref_c = '0;
    logic [3:0]  ref_a = '0;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    cascade_ctr4 #(.WIDTH(4), .ASYNC_CLR(1'b0)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
        .preset(preset[3:0]), .count(q0), .tc(tc0));
    cascade_ctr4 #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_mid (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par), .en_trk(tc0),
        .preset(preset[7:4]), .count(q1), .tc(tc1));
    cascade_ctr4 #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par), .en_trk(tc1),
        .preset(preset[11:8]), .count(q2), .tc(tc2));
    cascade_ctr4 #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_async (
        .clk(clk), .clr_n(a_clr_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
        .preset(preset[3:0]), .count(aq), .tc(atc));

    function automatic logic [11:0] nxt12(logic [11:0] cur, logic c, logic l,
                                          logic ep, logic et, logic [11:0] pre);
        if (!c)            return '0;
        else if (!l)       return pre;
        else if (ep && et) return cur + 12'd1;
        else               return cur;
    endfunction

    function automatic string tag(logic c, logic l, logic ep, logic et, logic [3:0] cur);
        if (!c)                       return "R3";
        if (!l)                       return "R4";
        if (!(ep && et))              return "R6";
        if (cur == 4'hF)              return "R1";
        return "R5";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check tc mid-cycle, check counts after the edge
    task automatic cycle(logic c, logic ac, logic l, logic ep, logic et, logic [11:0] pre);
        string t;
        @(negedge clk);
        clr_n = c; a_clr_n = ac; load_n = l; en_par = ep; en_trk = et; preset = pre;
        if (!ac) ref_a = '0;
        #1;
        chk("R7 tc0", {31'd0, tc0}, {31'd0, et && ref_c[3:0] == 4'hF});
        chk("R9 tc2", {31'd0, tc2}, {31'd0, et && ref_c == 12'hFFF});
        chk("R2 atc", {31'd0, atc}, {31'd0, et && ref_a == 4'hF});
        if (!ac) chk("R2 immediate clear", {28'd0, aq}, 32'd0);
        t = tag(c, l, ep, et, ref_c[3:0]);
        @(posedge clk);
        ref_c = nxt12(ref_c, c, l, ep, et, pre);
        ref_a = 4'(nxt12({8'd0, ref_a}, ac, l, ep, et, {8'd0, pre[3:0]}));
        #1;
        chk(t, {28'd0, q0}, {28'd0, ref_c[3:0]});
        chk("R9 chain", {20'd0, q2, q1, q0}, {20'd0, ref_c});
        chk("R2 async stage", {28'd0, aq}, {28'd0, ref_a});
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240613));
        repeat (3) @(posedge clk);
        #1;
        chk("R3 reset state", {20'd0, q2, q1, q0}, 32'd0);
        chk("R2 reset state", {28'd0, aq}, 32'd0);
        // R8: release then count at once
        cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        chk("R8 first count", {20'd0, q2, q1, q0}, 32'd1);
        // R1/R9: carries across both boundaries
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'hFFD);
        repeat (5) cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 12'h0FE);
        repeat (4) cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        // R7: en_par low does not affect tc, and holds the count
        cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 12'h00F);
        cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000);
        cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 12'h000);
        // R3: clear beats load; count unchanged mid-cycle
        @(negedge clk);
        clr_n = 1'b0; load_n = 1'b0; preset = 12'h5A5;
        #1;
        chk("R3 no early clear", {20'd0, q2, q1, q0}, {20'd0, ref_c});
        @(posedge clk); #1;
        chk("R3 clear over load", {20'd0, q2, q1, q0}, 32'd0);
        ref_c = '0;
        if (a_clr_n) ref_a = preset[3:0];
        // R4: load beats count
        cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 12'hA37);
        // R2: async clear mid-cycle from 15
        cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 12'h00F);
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 12'h000);
        cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic c, ac, l, ep, et;
            c  = ($urandom % 40) != 0;
            ac = ($urandom % 40) != 0;
            l  = ($urandom % 24) != 0;
            ep = ($urandom % 8) != 0;
            et = ($urandom % 8) != 0;
            cycle(c, ac, l, ep, et, 12'($urandom));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule